// File: doc/BRIEF.md
# Serial Audio Output Formatter

This block takes stereo PCM sample pairs from a valid/ready source and sends them out on a three-wire serial audio link: a bit clock, a frame clock that marks the channel, and one data line. Every frame has two halves of `SLOT_BITS` bit clocks each, left first. A sample occupies the top `SAMPLE_W` bit periods of its half (or the bottom ones when right-aligned), and every other bit period is driven zero. Four static controls shape the wire format. They choose left or right alignment, add an optional one-bit gap before the MSB, pick which bit-clock edge the far end samples on, and pick which frame-clock level means left.

In master mode the block makes both clocks itself from the system clock. It applies backpressure so that each frame carries exactly one new pair. In slave mode it follows an external bit clock and frame clock through synchronisers. It then has no say over the sample rate, so it keeps a one-deep holding register. A pair that overwrites an unsent pair, or a frame that has to resend the previous pair, raises a one-cycle slip pulse. The controls are meant to be changed only while reset is held.

Top module: `audio_ser_tx`

## Requirements
- R1: While reset is held, and on release, these outputs hold: `s_ready` = 1, `slip_o` = 0, `sdata_o` = 0. In master mode `bclk_o` = NOT `cfg_bpol` and `lrck_o` = `cfg_lpol` (the right-channel level).
- R2: In master mode, `bclk_o` changes level every `DIV_HALF` system clocks, so one bit period is 2*`DIV_HALF` clocks. `lrck_o` changes level after exactly `SLOT_BITS` sampling edges.
- R3: With `cfg_bpol` = 0 the far end samples on rising `bclk_o` edges. With `cfg_bpol` = 1 it samples on falling edges. `sdata_o` and `lrck_o` change only together with a `bclk_o` transition to the non-sampling level.
- R4: With `cfg_lpol` = 0, `lrck_o` high marks the left half. With `cfg_lpol` = 1, `lrck_o` high marks the right half. Each frame sends the left half first.
- R5: With `cfg_rjust` = 0 and `cfg_delay` = 0, the sample MSB goes in the first bit period after the frame-clock change. The sample follows MSB first, and the rest of the half is zero.
- R6: With `cfg_rjust` = 0 and `cfg_delay` = 1, the first bit period of each half is zero and the MSB goes in the second.
- R7: In master mode with `cfg_rjust` = 1, each half starts with `SLOT_BITS`-`SAMPLE_W` zero bits. The sample LSB goes in the last bit period of the half, and `cfg_delay` has no effect.
- R8: In slave mode (`cfg_master` = 0), bit timing follows `ext_bclk` and channel timing follows `ext_lrck`, using the same polarity controls. `cfg_rjust` is ignored, so data is left-aligned, and `bclk_o` and `lrck_o` are held at 0.
- R9: In master mode, `s_ready` is low while a pair is waiting. Accepted pairs go out one per frame, in order, left word in the left half. `slip_o` never rises.
- R10: In slave mode, `s_ready` is always 1. A pair accepted while an earlier one is still waiting replaces it, and this gives one `slip_o` pulse.
- R11: In slave mode, once any pair has been sent, a frame start with nothing waiting resends the previous pair and gives one `slip_o` pulse. Before any pair has been sent, zeros go out and no pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_master | input | 1 | 1 = generate clocks, 0 = follow external clocks |
| cfg_rjust | input | 1 | 1 = right-aligned (master only), 0 = left-aligned |
| cfg_delay | input | 1 | 1 = one zero bit before the MSB (left-aligned) |
| cfg_bpol | input | 1 | 0 = far end samples on rising bit clock, 1 = falling |
| cfg_lpol | input | 1 | 0 = high frame clock is left, 1 = high is right |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Pair accepted on this edge when valid |
| s_left | input | SAMPLE_W | Left sample |
| s_right | input | SAMPLE_W | Right sample |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_lrck | input | 1 | External frame clock (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| lrck_o | output | 1 | Generated frame clock (master mode) |
| sdata_o | output | 1 | Serial data |
| slip_o | output | 1 | One-cycle pulse per dropped or repeated pair |

## Verification
Some properties are checked on every cycle. The bit clock half-period must equal `DIV_HALF`. Data and frame clock may change only when the bit clock moves to its launch level. Master mode must never slip. Slave mode must keep `s_ready` high and both generated clocks low. The bench has to show the rest from whole frames. That covers the bit layout of each alignment and delay option across all polarity combinations, and pair ordering under backpressure. It also covers the drop and repeat cases with their exact slip counts when external clocks are driven, and the fact that right alignment is ignored in slave mode.

// File: rtl/audio_ser_pkg.sv
package audio_ser_pkg;

    // Channel carried by the current half-frame; the left half comes first.
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

endpackage

// File: rtl/ser_clk_div.sv
module ser_clk_div #(
    parameter int DIV_HALF  = 2,
    parameter int SLOT_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic bclk_int,
    output logic launch,
    output logic lr_next
);
    localparam int FRAME_BITS = 2 * SLOT_BITS;
    localparam int CNT_W      = $clog2(DIV_HALF + 1);
    localparam int POS_W      = $clog2(FRAME_BITS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             bclk;
        logic [POS_W-1:0] pos;
    } div_t;

    // Internal clock idles high; the first toggle is a launch edge into bit 0.
    localparam div_t DIV_RST = '{cnt: '0, bclk: 1'b1, pos: POS_W'(FRAME_BITS - 1)};

    div_t div_d, div_q;
    logic [POS_W-1:0] pos_inc;

    always_comb begin
        div_d   = div_q;
        launch  = 1'b0;
        pos_inc = (div_q.pos == POS_W'(FRAME_BITS - 1)) ? '0 : div_q.pos + 1'b1;
        lr_next = (pos_inc >= POS_W'(SLOT_BITS));
        if (!en) begin
            div_d = DIV_RST;
        end else if (div_q.cnt == CNT_W'(DIV_HALF - 1)) begin
            div_d.cnt  = '0;
            div_d.bclk = ~div_q.bclk;
            if (div_q.bclk) begin
                launch    = 1'b1;
                div_d.pos = pos_inc;
            end
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= DIV_RST;
        else        div_q <= div_d;
    end

    assign bclk_int = div_q.bclk;

endmodule

// File: rtl/ser_slave_sync.sv
module ser_slave_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ext_bclk,
    input  logic ext_lrck,
    input  logic bpol,
    input  logic lpol,
    output logic launch,
    output logic lr_next
);
    localparam int MSB = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sb;
        logic [SYNC_STAGES-1:0] sl;
        logic                   prev_b;
    } sync_t;

    sync_t sy_d, sy_q;
    logic  cur_int;
    logic  prev_int;

    always_comb begin
        sy_d        = sy_q;
        sy_d.sb     = {sy_q.sb[MSB-1:0], ext_bclk};
        sy_d.sl     = {sy_q.sl[MSB-1:0], ext_lrck};
        sy_d.prev_b = sy_q.sb[MSB];
        // Normalise to the internal clock: launch is its falling edge.
        cur_int  = sy_q.sb[MSB] ^ bpol;
        prev_int = sy_q.prev_b ^ bpol;
        launch   = en && prev_int && !cur_int;
        // Internal channel: 0 = left, 1 = right.
        lr_next  = sy_q.sl[MSB] ~^ lpol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

endmodule

// File: rtl/ser_sample_hold.sv
module ser_sample_hold #(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                master,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [SAMPLE_W-1:0] s_left,
    input  logic [SAMPLE_W-1:0] s_right,
    input  logic                frame_start,
    output logic [SAMPLE_W-1:0] nxt_left,
    output logic [SAMPLE_W-1:0] nxt_right,
    output logic                slip
);
    typedef struct packed {
        logic                full;
        logic [SAMPLE_W-1:0] hold_l;
        logic [SAMPLE_W-1:0] hold_r;
        logic [SAMPLE_W-1:0] cur_l;
        logic [SAMPLE_W-1:0] cur_r;
        logic                primed;
        logic                slip;
    } hold_t;

    hold_t hd_d, hd_q;
    logic  accept;

    always_comb begin
        hd_d      = hd_q;
        hd_d.slip = 1'b0;
        s_ready   = master ? !hd_q.full : 1'b1;
        accept    = s_valid && s_ready;

        if (frame_start) begin
            if (hd_q.full) begin
                hd_d.cur_l  = hd_q.hold_l;
                hd_d.cur_r  = hd_q.hold_r;
                hd_d.primed = 1'b1;
            end else if (!master && hd_q.primed) begin
                hd_d.slip = 1'b1;     // repeat of the previous pair
            end
        end

        if (accept) begin
            hd_d.hold_l = s_left;
            hd_d.hold_r = s_right;
            hd_d.full   = 1'b1;
            if (hd_q.full && !frame_start && !master) begin
                hd_d.slip = 1'b1;     // waiting pair overwritten
            end
        end else if (frame_start) begin
            hd_d.full = 1'b0;
        end

        nxt_left  = (frame_start && hd_q.full) ? hd_q.hold_l : hd_q.cur_l;
        nxt_right = (frame_start && hd_q.full) ? hd_q.hold_r : hd_q.cur_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hd_q <= '0;
        else        hd_q <= hd_d;
    end

    assign slip = hd_q.slip;

endmodule

// File: rtl/ser_shifter.sv
module ser_shifter
    import audio_ser_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int SLOT_BITS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic                lr_next,
    input  logic                rjust,
    input  logic                delay,
    input  logic [SAMPLE_W-1:0] nxt_left,
    input  logic [SAMPLE_W-1:0] nxt_right,
    output logic                frame_start,
    output logic                lr_out,
    output logic                sdata
);
    localparam int POS_W = $clog2(SLOT_BITS);
    localparam int IW    = $clog2(SAMPLE_W);
    localparam int PAD   = SLOT_BITS - SAMPLE_W;

    typedef struct packed {
        chan_e            lr;
        logic [POS_W-1:0] pos;
        logic             sdata;
    } shf_t;

    localparam shf_t SHF_RST = '{lr: CH_RIGHT, pos: POS_W'(SLOT_BITS - 1), sdata: 1'b0};

    shf_t sh_d, sh_q;
    logic new_half;

    // Kept outside the next-state block: the hold stage feeds back on it.
    assign new_half    = (chan_e'(lr_next) != sh_q.lr);
    assign frame_start = launch && new_half && (chan_e'(lr_next) == CH_LEFT);

    logic [POS_W-1:0]    pos_n;
    logic [POS_W-1:0]    offset;
    logic [SAMPLE_W-1:0] word;
    logic [IW-1:0]       sel;
    logic                bit_n;
    int                  idx;

    always_comb begin
        sh_d   = sh_q;
        pos_n  = new_half ? '0
               : (sh_q.pos == POS_W'(SLOT_BITS - 1)) ? sh_q.pos : sh_q.pos + 1'b1;
        word   = lr_next ? nxt_right : nxt_left;
        offset = rjust ? POS_W'(PAD) : POS_W'(delay);
        idx    = int'(pos_n) - int'(offset);
        sel    = '0;
        bit_n  = 1'b0;
        if (idx >= 0 && idx < SAMPLE_W) begin
            sel   = IW'(SAMPLE_W - 1 - idx);
            bit_n = word[sel];
        end
        if (launch) begin
            sh_d.lr    = chan_e'(lr_next);
            sh_d.pos   = pos_n;
            sh_d.sdata = bit_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= SHF_RST;
        else        sh_q <= sh_d;
    end

    assign lr_out = sh_q.lr;
    assign sdata  = sh_q.sdata;

endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx #(
    parameter int SAMPLE_W    = 24,
    parameter int SLOT_BITS   = 32,
    parameter int DIV_HALF    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_master,
    input  logic                cfg_rjust,
    input  logic                cfg_delay,
    input  logic                cfg_bpol,
    input  logic                cfg_lpol,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [SAMPLE_W-1:0] s_left,
    input  logic [SAMPLE_W-1:0] s_right,
    input  logic                ext_bclk,
    input  logic                ext_lrck,
    output logic                bclk_o,
    output logic                lrck_o,
    output logic                sdata_o,
    output logic                slip_o
);
    logic m_bclk, m_launch, m_lr;
    logic x_launch, x_lr;
    logic launch, lr_next, rjust_eff;
    logic frame_start, lr_q;
    logic [SAMPLE_W-1:0] nxt_left, nxt_right;

    ser_clk_div #(.DIV_HALF(DIV_HALF), .SLOT_BITS(SLOT_BITS)) div_i (
        .clk(clk), .rst_n(rst_n), .en(cfg_master),
        .bclk_int(m_bclk), .launch(m_launch), .lr_next(m_lr)
    );

    ser_slave_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .en(!cfg_master),
        .ext_bclk(ext_bclk), .ext_lrck(ext_lrck),
        .bpol(cfg_bpol), .lpol(cfg_lpol),
        .launch(x_launch), .lr_next(x_lr)
    );

    assign launch    = cfg_master ? m_launch : x_launch;
    assign lr_next   = cfg_master ? m_lr : x_lr;
    assign rjust_eff = cfg_rjust && cfg_master;

    ser_sample_hold #(.SAMPLE_W(SAMPLE_W)) hold_i (
        .clk(clk), .rst_n(rst_n), .master(cfg_master),
        .s_valid(s_valid), .s_ready(s_ready),
        .s_left(s_left), .s_right(s_right),
        .frame_start(frame_start),
        .nxt_left(nxt_left), .nxt_right(nxt_right),
        .slip(slip_o)
    );

    ser_shifter #(.SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS)) shf_i (
        .clk(clk), .rst_n(rst_n), .launch(launch), .lr_next(lr_next),
        .rjust(rjust_eff), .delay(cfg_delay),
        .nxt_left(nxt_left), .nxt_right(nxt_right),
        .frame_start(frame_start), .lr_out(lr_q), .sdata(sdata_o)
    );

    assign bclk_o = cfg_master && (m_bclk ^ cfg_bpol);
    assign lrck_o = cfg_master && (lr_q ~^ cfg_lpol);

endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk #(
    parameter int DIV_HALF = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cfg_master,
    input logic cfg_bpol,
    input logic s_ready,
    input logic bclk_o,
    input logic lrck_o,
    input logic sdata_o,
    input logic slip_o
);
    logic        prev_b;
    logic        seen;
    logic [15:0] gap;

    always_ff @(posedge clk) prev_b <= bclk_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= 1'b0;
            gap  <= '0;
        end else if (bclk_o != prev_b) begin
            seen <= 1'b1;
            gap  <= '0;
        end else if (gap != 16'hFFFF) begin
            gap <= gap + 1'b1;
        end
    end

    // R2
    bclk_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && seen && bclk_o != prev_b) |-> (gap == 16'(DIV_HALF - 1)));

    // R3
    data_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && sdata_o != $past(sdata_o)) |-> (bclk_o != $past(bclk_o) && bclk_o == cfg_bpol));

    // R3
    lrck_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && lrck_o != $past(lrck_o)) |-> (bclk_o != $past(bclk_o) && bclk_o == cfg_bpol));

    // R9
    slip_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_master |-> !slip_o);

    // R8
    slave_outs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_master |-> (!bclk_o && !lrck_o));

    // R10
    slave_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_master |-> s_ready);

endmodule

bind audio_ser_tx audio_ser_tx_chk #(.DIV_HALF(DIV_HALF)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_bpol(cfg_bpol),
    .s_ready(s_ready), .bclk_o(bclk_o), .lrck_o(lrck_o),
    .sdata_o(sdata_o), .slip_o(slip_o)
);

// File: tb/audio_ser_tx_tb.sv
module audio_ser_tx_tb_top;
    localparam int W    = 24;
    localparam int SLOT = 32;
    localparam int DIVH = 2;
    localparam int HB   = 6;
    localparam int FR   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_master = 1'b1, cfg_rjust = 1'b0, cfg_delay = 1'b0, cfg_bpol = 1'b0, cfg_lpol = 1'b0;
    logic s_valid = 1'b0;
    logic [W-1:0] s_left = '0, s_right = '0;
    logic ext_bclk = 1'b0, ext_lrck = 1'b0;
    logic s_ready, bclk_o, lrck_o, sdata_o, slip_o;

    audio_ser_tx #(.SAMPLE_W(W), .SLOT_BITS(SLOT), .DIV_HALF(DIVH)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_rjust(cfg_rjust),
        .cfg_delay(cfg_delay), .cfg_bpol(cfg_bpol), .cfg_lpol(cfg_lpol),
        .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
        .ext_bclk(ext_bclk), .ext_lrck(ext_lrck), .bclk_o(bclk_o), .lrck_o(lrck_o),
        .sdata_o(sdata_o), .slip_o(slip_o)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_err = 0;
    int slip_cnt = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [SLOT-1:0] build_slot(input logic [W-1:0] s, input bit rj, input bit dl);
        logic [SLOT-1:0] v = '0;
        for (int p = 0; p < SLOT; p++) begin
            int k = rj ? p - (SLOT - W) : p - int'(dl);
            if (k >= 0 && k < W) v[SLOT-1-p] = s[W-1-k];
        end
        return v;
    endfunction

    always @(negedge clk) if (rst_n && slip_o) slip_cnt++;

    // Master-mode receiver model
    bit mon_en = 0;
    logic m_prev_b, m_prev_lr;
    bit m_started, m_rx_seen;
    int m_idx, cyc_since, period_err, len_err, slot_n;
    logic [SLOT-1:0] m_vec;
    bit m_left;
    logic [SLOT-1:0] slot_vec [0:63];
    bit slot_left [0:63];

    always @(negedge clk) if (mon_en) begin
        cyc_since++;
        if (bclk_o != m_prev_b) begin
            if (bclk_o == ~cfg_bpol) begin
                if (m_rx_seen && cyc_since != 2 * DIVH) period_err++;
                m_rx_seen = 1;
                cyc_since = 0;
                if (lrck_o != m_prev_lr) begin
                    if (m_started && m_idx != SLOT) len_err++;
                    m_started = 1;
                    m_idx = 0;
                    m_left = (lrck_o ^ cfg_lpol);
                end else if (m_started && m_idx >= SLOT) begin
                    len_err++;
                end
                if (m_started && m_idx < SLOT) begin
                    m_vec[SLOT-1-m_idx] = sdata_o;
                    m_idx++;
                    if (m_idx == SLOT && slot_n < 64) begin
                        slot_vec[slot_n] = m_vec;
                        slot_left[slot_n] = m_left;
                        slot_n++;
                    end
                end
                m_prev_lr = lrck_o;
            end
            m_prev_b = bclk_o;
        end
    end

    task automatic reset_phase();
        rst_n = 1'b0;
        s_valid = 1'b0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(s_ready == 1'b1, "R1 ready", 64'(s_ready), 64'd1);
        chk(slip_o == 1'b0 && sdata_o == 1'b0, "R1 slip/data", {62'd0, slip_o, sdata_o}, 64'd0);
        if (cfg_master)
            chk(bclk_o == ~cfg_bpol && lrck_o == cfg_lpol, "R1 clocks",
                {62'd0, bclk_o, lrck_o}, {62'd0, ~cfg_bpol, cfg_lpol});
    endtask

    task automatic run_master(input bit rj, input bit dl, input bit bp, input bit lp);
        logic [W-1:0] acc_l [0:63];
        logic [W-1:0] acc_r [0:63];
        int acc_n = 0;
        int slip0;
        bit took;
        int npairs;
        cfg_master = 1; cfg_rjust = rj; cfg_delay = dl; cfg_bpol = bp; cfg_lpol = lp;
        reset_phase();
        m_prev_b = bclk_o; m_prev_lr = lrck_o;
        m_started = 0; m_rx_seen = 0; m_idx = 0; cyc_since = 0;
        period_err = 0; len_err = 0; slot_n = 0;
        mon_en = 1;
        slip0 = slip_cnt;
        s_left = W'($urandom); s_right = W'($urandom); s_valid = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        took = s_valid && s_ready;
        if (took) begin acc_l[acc_n] = s_left; acc_r[acc_n] = s_right; acc_n++; end
        repeat (FR * 2 * SLOT * 2 * DIVH + 8) begin
            @(negedge clk);
            if (took) begin
                s_left = W'($urandom);
                s_right = W'($urandom);
                if (acc_n % 3 == 2) begin s_left = '1; s_right = {1'b1, {(W-1){1'b0}}}; end
            end
            took = s_valid && s_ready;
            if (took && acc_n < 64) begin acc_l[acc_n] = s_left; acc_r[acc_n] = s_right; acc_n++; end
        end
        mon_en = 0;
        s_valid = 1'b0;
        npairs = slot_n / 2;
        chk(npairs >= FR - 1, "R2 frame count", 64'(npairs), 64'(FR - 1));
        chk(period_err == 0, "R2 bit period", 64'(period_err), 64'd0);
        chk(len_err == 0, "R2 half length", 64'(len_err), 64'd0);
        chk(slip_cnt == slip0, "R9 no slip", 64'(slip_cnt - slip0), 64'd0);
        chk(acc_n <= npairs + 2, "R9 backpressure", 64'(acc_n), 64'(npairs + 2));
        for (int k = 0; k < npairs && k < acc_n; k++) begin
            // R4: channel order and level meaning
            chk(slot_left[2*k] == 1 && slot_left[2*k+1] == 0, "R4 channel",
                {62'd0, slot_left[2*k], slot_left[2*k+1]}, 64'd2);
            // R5 / R6 / R7 bit layout, R3 sampling edge
            chk(slot_vec[2*k] == build_slot(acc_l[k], rj, dl),
                rj ? "R7 left" : (dl ? "R6 left" : "R5 left"),
                64'(slot_vec[2*k]), 64'(build_slot(acc_l[k], rj, dl)));
            chk(slot_vec[2*k+1] == build_slot(acc_r[k], rj, dl),
                bp ? "R3 right" : (rj ? "R7 right" : "R9 right"),
                64'(slot_vec[2*k+1]), 64'(build_slot(acc_r[k], rj, dl)));
        end
    endtask

    task automatic slave_frame(input int npush, input logic [W-1:0] l0, r0, l1, r1,
                               output logic [SLOT-1:0] cap_l, cap_r, output bit outs_ok);
        outs_ok = 1;
        cap_l = '0; cap_r = '0;
        for (int b = 0; b < 2 * SLOT; b++) begin
            logic lr = (b >= SLOT);
            @(negedge clk);
            ext_bclk = 1'b0 ^ cfg_bpol;
            ext_lrck = lr ~^ cfg_lpol;
            for (int c = 0; c < HB; c++) begin
                if (c > 0) @(negedge clk);
                if (b == 40 && c < npush) begin
                    s_valid = 1'b1;
                    s_left = (c == 0) ? l0 : l1;
                    s_right = (c == 0) ? r0 : r1;
                end else begin
                    s_valid = 1'b0;
                end
                if (b == 40 && (bclk_o || lrck_o || !s_ready)) outs_ok = 0;
            end
            @(negedge clk);
            s_valid = 1'b0;
            if (b < SLOT) cap_l[SLOT-1-b] = sdata_o;
            else          cap_r[2*SLOT-1-b] = sdata_o;
            ext_bclk = 1'b1 ^ cfg_bpol;
            repeat (HB - 1) @(negedge clk);
        end
    endtask

    task automatic run_slave(input bit rj, input bit dl, input bit bp, input bit lp);
        int pushes [0:5] = '{1, 0, 2, 1, 0, 0};
        logic [W-1:0] exp_l = '0, exp_r = '0, hl = '0, hr = '0;
        bit full_m = 0, primed = 0, rep;
        logic [SLOT-1:0] cl, cr;
        bit ok;
        int s0, drops;
        cfg_master = 0; cfg_rjust = rj; cfg_delay = dl; cfg_bpol = bp; cfg_lpol = lp;
        ext_bclk = 1'b1 ^ bp;
        ext_lrck = 1'b1 ~^ lp;
        reset_phase();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        for (int f = 0; f < 6; f++) begin
            logic [W-1:0] l0 = W'($urandom), r0 = W'($urandom), l1 = W'($urandom), r1 = W'($urandom);
            if (full_m) begin exp_l = hl; exp_r = hr; primed = 1; rep = 0; end
            else rep = primed;
            full_m = 0;
            s0 = slip_cnt;
            slave_frame(pushes[f], l0, r0, l1, r1, cl, cr, ok);
            drops = (pushes[f] > 1) ? pushes[f] - 1 : 0;
            if (pushes[f] == 1) begin hl = l0; hr = r0; full_m = 1; end
            if (pushes[f] == 2) begin hl = l1; hr = r1; full_m = 1; end
            // R8: left-aligned regardless of cfg_rjust, clocks held low
            chk(cl == build_slot(exp_l, 0, dl), rj ? "R8 left" : "R5 slave left",
                64'(cl), 64'(build_slot(exp_l, 0, dl)));
            chk(cr == build_slot(exp_r, 0, dl), dl ? "R6 slave right" : "R8 right",
                64'(cr), 64'(build_slot(exp_r, 0, dl)));
            chk(ok, "R8 outputs low, R10 ready high", 64'(ok), 64'd1);
            // R10 drops, R11 repeats
            chk(slip_cnt - s0 == int'(rep) + drops, rep ? "R11 repeat slip" : "R10 drop slip",
                64'(slip_cnt - s0), 64'(int'(rep) + drops));
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int cfg = 0; cfg < 16; cfg++)
            run_master(cfg[3], cfg[2], cfg[1], cfg[0]);
        run_slave(1'b1, 1'b0, 1'b0, 1'b0);
        run_slave(1'b1, 1'b1, 1'b1, 1'b1);
        summary();
        $finish;
    end

endmodule